// File: doc/BRIEF.md
# Keyboard Scan and Wake-Up Counter Peripheral

This peripheral sits on a 16-bit processor address bus and holds one 13-bit counter. The counter has two jobs. Its low seven bits drive the scan lines of a seven-line, five-column key matrix, and its top bit serves as a wake-up timer flag once a half-second tick has advanced it 4096 times. Software controls the counter through address accesses alone. An access to one address window clears it, and an access to another window advances it by one. The data value and the direction of the access do not matter, so a plain test-style read has the same effect as a write. The counter address windows ignore the low ten address bits.

A registered eight-bit input port combines several signals: the five key-return columns of whichever scan lines are active, the on/clear key, a low-battery flag and counter bit 12. Two more address windows, each 512 bytes wide, produce one-cycle strobes. One strobe requests power-down. The other enables the programming pulse used to write external storage packs.

The key matrix, the power supply and the pulse generator sit outside the block and appear only as pins.

Top module: `kbclk_periph`

## Requirements
- R1: A valid access to any address 0x2800..0x2BFF clears the counter to 0 at that clock edge, whatever the low ten address bits are.
- R2: A valid access to any address 0x3000..0x33FF adds one to the counter at that clock edge, and the counter wraps from 0x1FFF to 0.
- R3: A cycle without a valid access, or with an access outside the four windows (for example 0x27FF, 0x3400, 0x0015, 0x4000), leaves the counter unchanged and raises no strobe.
- R4: `scan_n[i]` equals counter bit i, and 0 means that line is active. After a clear, all seven lines are active. The values 0x3F, 0x5F, 0x6F, 0x77, 0x7B, 0x7D and 0x7E activate only line 6, 5, 4, 3, 2, 1 and 0 respectively.
- R5: `port_q` bit k+2 (k = 0..4) reads 0 exactly when some key `key_down[l*5+k]` is pressed on a line l that is active.
- R6: `port_q` bit 7 reads 0 while `onclr` is high, and `port_q` bit 0 reads 0 while `batt_low` is high.
- R7: `port_q` bit 1 equals counter bit 12. `port_q` is registered and reflects the counter and the input pins from the previous cycle.
- R8: `pwr_off` is high for exactly the one cycle after a valid access to 0x2E00..0x2FFF.
- R9: `pulse_en` is high for exactly the one cycle after a valid access to 0x2C00..0x2DFF.
- R10: While `rst` is high, the counter is 0, both strobes are low and `port_q` is 0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | A bus access occurs this cycle (read or write) |
| acc_addr | input | 16 | Bus address of the access |
| key_down | input | 35 | Pressed keys, bit l*5+k = line l, column k |
| onclr | input | 1 | On/clear key pressed |
| batt_low | input | 1 | Battery low flag |
| scan_n | output | 7 | Scan lines, active low |
| port_q | output | 8 | Registered input port value |
| pwr_off | output | 1 | One-cycle power-down strobe |
| pulse_en | output | 1 | One-cycle programming-pulse enable strobe |

## Verification
The assertions assume that `acc_addr` is meaningful only while `acc_valid` is high, and that at most one access arrives per cycle. Because of the second assumption, a clear and an increment never collide. The stimulus drives exactly one address per access cycle and drops `acc_valid` between accesses. It varies the ignored low address bits across whole windows, so the window checks do not rely on the base address alone. Key, on/clear and battery inputs change only between accesses, so every port sample reflects a settled counter.

// File: rtl/kbclk_pkg.sv
package kbclk_pkg;
  // Which address windows the current access hits
  typedef struct packed {
    logic clr;
    logic step;
    logic off;
    logic pulse;
  } acc_hit_t;

  // True when addr lies in the window starting at base with ign low bits ignored
  function automatic logic in_window(input logic [15:0] addr,
                                     input logic [15:0] base,
                                     input int unsigned ign);
    logic [15:0] diff;
    diff = (addr ^ base) >> ign;
    return diff == 16'h0000;
  endfunction
endpackage

// File: rtl/kbclk_decode.sv
module kbclk_decode
  import kbclk_pkg::*;
#(
  parameter int unsigned ADDR_W     = 16,
  parameter logic [15:0] CLR_BASE   = 16'h2800,
  parameter logic [15:0] STEP_BASE  = 16'h3000,
  parameter logic [15:0] OFF_BASE   = 16'h2E00,
  parameter logic [15:0] PULSE_BASE = 16'h2C00,
  parameter int unsigned CNT_IGN    = 10,
  parameter int unsigned STB_IGN    = 9
) (
  input  logic              valid,
  input  logic [ADDR_W-1:0] addr,
  output acc_hit_t          hit
);
  logic [15:0] a16;

  assign a16 = 16'(addr);

  always_comb begin
    hit       = '0;
    hit.clr   = valid && in_window(a16, CLR_BASE, CNT_IGN);
    hit.step  = valid && in_window(a16, STEP_BASE, CNT_IGN);
    hit.off   = valid && in_window(a16, OFF_BASE, STB_IGN);
    hit.pulse = valid && in_window(a16, PULSE_BASE, STB_IGN);
  end
endmodule

// File: rtl/kbclk_counter.sv
module kbclk_counter #(
  parameter int unsigned CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             step,
  output logic [CNT_W-1:0] cnt_q
);
  // Clear wins over step; the modulo-2^CNT_W wrap is the natural add overflow
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (step) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/kbclk_keyport.sv
module kbclk_keyport #(
  parameter int unsigned LINES  = 7,
  parameter int unsigned KEYS   = 5,
  localparam int unsigned NKEY  = LINES * KEYS,
  localparam int unsigned PORT_W = KEYS + 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LINES-1:0]  scan_n,
  input  logic [NKEY-1:0]   key_down,
  input  logic              onclr,
  input  logic              batt_low,
  input  logic              wake_bit,
  output logic [PORT_W-1:0] port_q
);
  logic [KEYS-1:0] col_hit;

  // A column reads pressed when any key in it sits on an active line
  for (genvar k = 0; k < KEYS; k++) begin : g_col
    logic [LINES-1:0] per_line;
    for (genvar l = 0; l < LINES; l++) begin : g_line
      assign per_line[l] = key_down[l*KEYS + k] & ~scan_n[l];
    end
    assign col_hit[k] = |per_line;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      port_q <= '1;
    end else begin
      port_q <= {~onclr, ~col_hit, wake_bit, ~batt_low};
    end
  end
endmodule

// File: rtl/kbclk_periph.sv
module kbclk_periph
  import kbclk_pkg::*;
#(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned CNT_W      = 13,
  parameter int unsigned LINES      = 7,
  parameter int unsigned KEYS       = 5,
  parameter logic [15:0] CLR_BASE   = 16'h2800,
  parameter logic [15:0] STEP_BASE  = 16'h3000,
  parameter logic [15:0] OFF_BASE   = 16'h2E00,
  parameter logic [15:0] PULSE_BASE = 16'h2C00,
  parameter int unsigned CNT_IGN    = 10,
  parameter int unsigned STB_IGN    = 9,
  localparam int unsigned NKEY      = LINES * KEYS,
  localparam int unsigned PORT_W    = KEYS + 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [NKEY-1:0]   key_down,
  input  logic              onclr,
  input  logic              batt_low,
  output logic [LINES-1:0]  scan_n,
  output logic [PORT_W-1:0] port_q,
  output logic              pwr_off,
  output logic              pulse_en
);
  acc_hit_t         hit;
  logic [CNT_W-1:0] cnt_q;

  kbclk_decode #(
    .ADDR_W(ADDR_W), .CLR_BASE(CLR_BASE), .STEP_BASE(STEP_BASE),
    .OFF_BASE(OFF_BASE), .PULSE_BASE(PULSE_BASE),
    .CNT_IGN(CNT_IGN), .STB_IGN(STB_IGN)
  ) u_dec (
    .valid(acc_valid),
    .addr (acc_addr),
    .hit  (hit)
  );

  kbclk_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk  (clk),
    .rst  (rst),
    .clr  (hit.clr),
    .step (hit.step),
    .cnt_q(cnt_q)
  );

  assign scan_n = cnt_q[LINES-1:0];

  kbclk_keyport #(.LINES(LINES), .KEYS(KEYS)) u_port (
    .clk     (clk),
    .rst     (rst),
    .scan_n  (scan_n),
    .key_down(key_down),
    .onclr   (onclr),
    .batt_low(batt_low),
    .wake_bit(cnt_q[CNT_W-1]),
    .port_q  (port_q)
  );

  // Single-cycle registered strobes
  always_ff @(posedge clk) begin
    if (rst) begin
      pwr_off  <= 1'b0;
      pulse_en <= 1'b0;
    end else begin
      pwr_off  <= hit.off;
      pulse_en <= hit.pulse;
    end
  end
endmodule

// File: rtl/kbclk_chk.sv
module kbclk_chk #(
  parameter int unsigned CNT_W  = 13,
  parameter int unsigned LINES  = 7,
  parameter int unsigned PORT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             acc_valid,
  input logic [15:0]      acc_addr,
  input logic [CNT_W-1:0] cnt_q,
  input logic [LINES-1:0] scan_n,
  input logic [PORT_W-1:0] port_q,
  input logic             pwr_off,
  input logic             pulse_en
);
  logic a_clr, a_step, a_off, a_pulse;
  assign a_clr   = acc_valid && (acc_addr[15:10] == 6'b001010);
  assign a_step  = acc_valid && (acc_addr[15:10] == 6'b001100);
  assign a_off   = acc_valid && (acc_addr[15:9]  == 7'b0010111);
  assign a_pulse = acc_valid && (acc_addr[15:9]  == 7'b0010110);

  // R1
  clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
    a_clr |=> cnt_q == '0);

  // R2
  step_plus_one_chk: assert property (@(posedge clk) disable iff (rst)
    a_step |=> cnt_q == $past(cnt_q) + 1'b1);

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(a_clr || a_step) |=> $stable(cnt_q));

  // R4
  scan_follow_chk: assert property (@(posedge clk) disable iff (rst)
    scan_n == cnt_q[LINES-1:0]);

  // R7
  wake_bit_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> port_q[1] == $past(cnt_q[CNT_W-1]));

  // R8
  off_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    pwr_off |-> $past(a_off));

  // R9
  pulse_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    pulse_en |-> $past(a_pulse));

  // R8
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({pwr_off, pulse_en}));
endmodule

bind kbclk_periph kbclk_chk #(.CNT_W(CNT_W), .LINES(LINES), .PORT_W(PORT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .acc_valid(acc_valid),
  .acc_addr (16'(acc_addr)),
  .cnt_q    (cnt_q),
  .scan_n   (scan_n),
  .port_q   (port_q),
  .pwr_off  (pwr_off),
  .pulse_en (pulse_en)
);

// File: tb/kbclk_periph_test.sv
module kbclk_periph_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_valid = 1'b0;
  logic [15:0] acc_addr = 16'h0000;
  logic [34:0] key_down = '0;
  logic        onclr = 1'b0;
  logic        batt_low = 1'b0;
  logic [6:0]  scan_n;
  logic [7:0]  port_q;
  logic        pwr_off, pulse_en;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  logic [12:0] model = '0;

  kbclk_periph uut (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .key_down(key_down), .onclr(onclr), .batt_low(batt_low),
    .scan_n(scan_n), .port_q(port_q), .pwr_off(pwr_off), .pulse_en(pulse_en)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input logic ok, input string req,
                       input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=<%0d", cyc, WATCHDOG);
      finish_run();
    end
  end

  function automatic logic [7:0] exp_port(input logic [12:0] c, input logic [34:0] kd,
                                          input logic oc, input logic bl);
    logic [7:0] p;
    p[0] = ~bl;
    p[1] = c[12];
    for (int k = 0; k < 5; k++) begin
      logic hit = 1'b0;
      for (int l = 0; l < 7; l++)
        if (kd[l*5+k] && !c[l]) hit = 1'b1;
      p[k+2] = ~hit;
    end
    p[7] = ~oc;
    return p;
  endfunction

  // One access cycle; on return the edge has taken effect
  task automatic access(input logic [15:0] a);
    @(negedge clk);
    acc_valid = 1'b1;
    acc_addr  = a;
    @(negedge clk);
    acc_valid = 1'b0;
    acc_addr  = 16'hFFFF;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic load(input logic [12:0] v);
    access(16'h2800);
    model = '0;
    for (int i = 0; i < int'(v); i++) begin
      access(16'h3000 | 16'(i[9:0]));
      model++;
    end
  endtask

  initial begin
    logic [6:0] one_line [7];
    one_line[0] = 7'h7E; one_line[1] = 7'h7D; one_line[2] = 7'h7B;
    one_line[3] = 7'h77; one_line[4] = 7'h6F; one_line[5] = 7'h5F;
    one_line[6] = 7'h3F;

    // R10: reset state
    repeat (3) @(negedge clk);
    check(scan_n == 7'h00, "R10 scan during reset", 16'(scan_n), 16'h0);
    check(port_q == 8'hFF, "R10 port during reset", 16'(port_q), 16'hFF);
    check(!pwr_off && !pulse_en, "R10 strobes during reset",
          16'({pwr_off, pulse_en}), 16'h0);
    rst = 1'b0;
    settle();
    settle();
    check(port_q == 8'hFD, "R10 port after reset", 16'(port_q), 16'hFD);

    // R2/R7/R4: full sweep with varied ignored bits, including the wrap
    for (int i = 0; i < 8192; i++) begin
      access(16'h3000 | 16'((i * 37) & 16'h03FF));
      model++;
      check(scan_n == model[6:0], "R2 R4 count on scan lines",
            16'(scan_n), 16'(model[6:0]));
      settle();
      check(port_q == exp_port(model, key_down, onclr, batt_low),
            "R7 port wake bit", 16'(port_q),
            16'(exp_port(model, key_down, onclr, batt_low)));
    end
    check(model == 13'h0 && scan_n == 7'h00, "R2 wrap to zero", 16'(scan_n), 16'h0);

    // R1: clear from nonzero with ignored bits set
    load(13'd90);
    access(16'h2BFF);
    model = '0;
    check(scan_n == 7'h00, "R1 clear at 0x2BFF", 16'(scan_n), 16'h0);
    load(13'd5);
    access(16'h2A55);
    model = '0;
    check(scan_n == 7'h00, "R1 clear at 0x2A55", 16'(scan_n), 16'h0);

    // R3: outside addresses and idle cycles change nothing
    load(13'd21);
    foreach (one_line[i]) begin end
    access(16'h27FF);
    check(scan_n == 7'd21 && !pwr_off && !pulse_en, "R3 addr 0x27FF",
          16'(scan_n), 16'd21);
    access(16'h3400);
    check(scan_n == 7'd21 && !pwr_off && !pulse_en, "R3 addr 0x3400",
          16'(scan_n), 16'd21);
    access(16'h0015);
    check(scan_n == 7'd21, "R3 addr 0x0015", 16'(scan_n), 16'd21);
    access(16'h4000);
    check(scan_n == 7'd21, "R3 addr 0x4000", 16'(scan_n), 16'd21);
    @(negedge clk) acc_addr = 16'h3000;
    repeat (3) settle();
    check(scan_n == 7'd21, "R3 address without valid", 16'(scan_n), 16'd21);

    // R4/R5: each single-line value against every key position
    for (int l = 0; l < 7; l++) begin
      load(13'(one_line[l]));
      check(scan_n == one_line[l], "R4 single line value",
            16'(scan_n), 16'(one_line[l]));
      for (int p = 0; p < 35; p++) begin
        key_down = 35'd1 << p;
        settle();
        settle();
        check(port_q == exp_port(model, key_down, onclr, batt_low),
              "R5 key return", 16'(port_q),
              16'(exp_port(model, key_down, onclr, batt_low)));
      end
      key_down = '0;
    end

    // R5: all lines active after clear, several keys at once
    access(16'h2800);
    model = '0;
    key_down = 35'h4_0000_0021;
    settle();
    settle();
    check(port_q == exp_port(model, key_down, 1'b0, 1'b0), "R5 all lines active",
          16'(port_q), 16'(exp_port(model, key_down, 1'b0, 1'b0)));
    key_down = '0;

    // R6: on/clear and low battery
    onclr = 1'b1;
    settle();
    settle();
    check(port_q == 8'h7D, "R6 on/clear low", 16'(port_q), 16'h7D);
    onclr = 1'b0;
    batt_low = 1'b1;
    settle();
    settle();
    check(port_q == 8'hFC, "R6 battery low", 16'(port_q), 16'hFC);
    batt_low = 1'b0;

    // R8/R9: strobes, one cycle each, at window edges
    access(16'h2FFF);
    check(pwr_off && !pulse_en, "R8 off strobe 0x2FFF", 16'({pwr_off, pulse_en}), 16'h2);
    settle();
    check(!pwr_off, "R8 off strobe one cycle", 16'(pwr_off), 16'h0);
    access(16'h2E00);
    check(pwr_off && !pulse_en, "R8 off strobe 0x2E00", 16'({pwr_off, pulse_en}), 16'h2);
    access(16'h2C00);
    check(pulse_en && !pwr_off, "R9 pulse strobe 0x2C00", 16'({pwr_off, pulse_en}), 16'h1);
    settle();
    check(!pulse_en, "R9 pulse strobe one cycle", 16'(pulse_en), 16'h0);
    access(16'h2DFF);
    check(pulse_en && !pwr_off, "R9 pulse strobe 0x2DFF", 16'({pwr_off, pulse_en}), 16'h1);
    check(scan_n == 7'h00, "R3 strobe windows leave count", 16'(scan_n), 16'h0);

    finish_run();
  end
endmodule